// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits inside a processor core and performs the hardware steps of entering an interrupt handler once the core has decided to take an interrupt of a given level. When a request is accepted it captures the status word, program counter, vector base and the three banked stack pointers. It then switches to the proper supervisor stack and pushes an exception frame one 16-bit word at a time through a write port. Next it reads the 32-bit handler address as two 16-bit words through a read port, rewrites the status word and hands back the new program counter, status word and stack pointers with a one-cycle completion pulse.

A model input selects between a base core and an extended core. The extended core has a separate master stack. When the master bit is set at entry, the extended core saves the master stack, moves to the interrupt stack, pushes a second short-lived frame there and clears the master bit. A stop input parks the core in a halted state; taking a request while halted wakes it and raises a one-cycle restart pulse for the scheduler. Priority masking and instruction decode happen elsewhere.

Top module: `irq_entry_seq`

## Requirements
- R1: The handler address is read from vbr_in + 0x60 + 4*level as two 16-bit reads, the upper half at the lower address, and appears on pc_out at completion.
- R2: If sr_in bit 13 (supervisor) is 0 at acceptance, usp_out becomes a7_in and the frame goes on isp_in (or on msp_in when the extended model is chosen and sr_in bit 12 is 1); if bit 13 is 1 the frame goes on a7_in and usp_out equals usp_in.
- R3: A frame is four predecremented word writes from stack pointer P: P-2 gets {format[3:0], offset[11:0]}, P-4 gets PC[15:0], P-6 gets PC[31:16], P-8 gets the frame's status word; the stack ends at P-8.
- R4: The first frame uses format 0 and the status word captured at acceptance; sr_out is (old & 0x38FF) | 0x2000 | level<<8, except for bit 12 as in R5.
- R5: In the extended model, when the rewritten status word has bit 12 set, msp_out becomes the stack after the first frame, a second frame with format 1 and the rewritten status word is pushed from isp_in, a7_out ends at isp_in-8 and sr_out bit 12 is cleared.
- R6: In the base model bit 12 has no effect on the stack choice, no second frame is written, and sr_out keeps bit 12; msp_out equals msp_in.
- R7: While a write or read request is held without ready, its address and data stay unchanged.
- R8: done is high for exactly one cycle at completion; busy is high from the cycle after acceptance until done; after reset busy, done, halted and wr_valid are 0.
- R9: A request that arrives while busy is ignored: no further writes follow and the results belong to the first request.
- R10: halt_set while idle raises halted; accepting a request while halted clears halted and pulses restart for one cycle, and halted is 0 after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Take an interrupt now (sampled only when idle) |
| req_level | input | 3 | Interrupt level of the request |
| halt_set | input | 1 | Core enters the stopped state |
| model_ext | input | 1 | 1 selects the extended core with master stack |
| sr_in | input | 16 | Status word at entry |
| pc_in | input | 32 | Return program counter |
| vbr_in | input | 32 | Vector table base |
| a7_in | input | 32 | Active stack pointer |
| usp_in | input | 32 | Banked user stack pointer |
| isp_in | input | 32 | Banked interrupt stack pointer |
| msp_in | input | 32 | Banked master stack pointer |
| wr_valid | output | 1 | Word write request |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 16 | Write data |
| wr_ready | input | 1 | Write accepted |
| rd_valid | output | 1 | Word read request |
| rd_addr | output | 32 | Read byte address |
| rd_data | input | 16 | Read data, valid with rd_ready |
| rd_ready | input | 1 | Read completes |
| busy | output | 1 | Entry in progress |
| halted | output | 1 | Core is stopped |
| restart | output | 1 | One-cycle wake pulse |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 32 | Handler address |
| sr_out | output | 16 | Rewritten status word |
| a7_out | output | 32 | Active stack pointer after entry |
| usp_out | output | 32 | User stack pointer after entry |
| msp_out | output | 32 | Master stack pointer after entry |

## Verification
Every cycle the assertions check that stalled memory requests hold address and data, that consecutive frame writes step down by two bytes, that done is a lone pulse with busy dropped, that the completed status word is in supervisor state with trace bits clear, and that restart only appears in a busy, awake state. The actual frame contents and addresses, the stack chosen for each combination of model, supervisor and master bits, the second frame, the handler address and the dropping of a request made while busy can only be shown by the bench's scenarios comparing each write and each result against values worked out from the requirements.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_FRAME2,
    ST_VEC
  } seq_state_t;

  localparam logic [15:0] SR_KEEP_MASK = 16'h38FF;
  localparam logic [15:0] SR_SUPER_SET = 16'h2000;
  localparam logic [11:0] VEC_BASE     = 12'h060;
  localparam int          SR_S_BIT     = 13;
  localparam int          SR_M_BIT     = 12;
  localparam logic [3:0]  FMT_NORMAL   = 4'h0;
  localparam logic [3:0]  FMT_THROW    = 4'h1;

  function automatic logic [11:0] vec_offset(input logic [2:0] lvl);
    return VEC_BASE + {7'b0, lvl, 2'b00};
  endfunction
endpackage

// File: rtl/irq_frame_writer.sv
module irq_frame_writer #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int NW = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [AW-1:0]      sp_in,
  input  logic [NW-1:0][DW-1:0] words,
  output logic               wr_valid,
  output logic [AW-1:0]      wr_addr,
  output logic [DW-1:0]      wr_data,
  input  logic               wr_ready,
  output logic               fin,
  output logic [AW-1:0]      sp_out
);
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [IW-1:0] idx;
  logic          last;
  assign last = (idx == IW'(NW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      idx      <= '0;
      fin      <= 1'b0;
      sp_out   <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        idx      <= '0;
        wr_valid <= 1'b1;
        wr_addr  <= sp_in - STEP;
        wr_data  <= words[0];
      end else if (wr_valid && wr_ready) begin
        if (last) begin
          wr_valid <= 1'b0;
          fin      <= 1'b1;
          sp_out   <= wr_addr;
        end else begin
          idx     <= idx + 1'b1;
          wr_addr <= wr_addr - STEP;
          wr_data <= words[idx + 1'b1];
        end
      end
    end
  end

  // R7: a stalled write keeps address and data
  a_r7_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready && !start) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R3: frame words go to descending addresses
  a_r3_predec: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready && !last && !start) |=> (wr_valid && wr_addr == $past(wr_addr) - STEP));
endmodule

// File: rtl/irq_vector_reader.sv
module irq_vector_reader #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   base,
  output logic            rd_valid,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data,
  input  logic            rd_ready,
  output logic            fin,
  output logic [2*DW-1:0] value
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic          phase;
  logic [DW-1:0] upper;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      phase    <= 1'b0;
      upper    <= '0;
      fin      <= 1'b0;
      value    <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        rd_valid <= 1'b1;
        rd_addr  <= base;
        phase    <= 1'b0;
      end else if (rd_valid && rd_ready) begin
        if (!phase) begin
          upper   <= rd_data;
          rd_addr <= rd_addr + STEP;
          phase   <= 1'b1;
        end else begin
          value    <= {upper, rd_data};
          rd_valid <= 1'b0;
          fin      <= 1'b1;
        end
      end
    end
  end

  // R7: a stalled read keeps its address
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !start) |=> (rd_valid && $stable(rd_addr)));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_level,
  input  logic          halt_set,
  input  logic          model_ext,
  input  logic [15:0]   sr_in,
  input  logic [31:0]   pc_in,
  input  logic [AW-1:0] vbr_in,
  input  logic [AW-1:0] a7_in,
  input  logic [AW-1:0] usp_in,
  input  logic [AW-1:0] isp_in,
  input  logic [AW-1:0] msp_in,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_ready,
  output logic          busy,
  output logic          halted,
  output logic          restart,
  output logic          done,
  output logic [31:0]   pc_out,
  output logic [15:0]   sr_out,
  output logic [AW-1:0] a7_out,
  output logic [AW-1:0] usp_out,
  output logic [AW-1:0] msp_out
);
  localparam int NW = 4;

  seq_state_t state;
  logic [2:0]    lvl_r;
  logic          ext_r;
  logic [31:0]   pc_r;
  logic [15:0]   sr_old, sr_r;
  logic [AW-1:0] vaddr_r, isp_r, sp_r, usp_r, msp_r;
  logic [NW-1:0][DW-1:0] fw_words;
  logic          fw_start, fw_fin, vr_start, vr_fin;
  logic [AW-1:0] fw_sp;
  logic [31:0]   vr_value;
  logic [11:0]   off_in, off_r;
  logic [15:0]   sr_new;

  assign off_in = vec_offset(req_level);
  assign off_r  = vec_offset(lvl_r);
  assign sr_new = (sr_old & SR_KEEP_MASK) | SR_SUPER_SET | {5'b0, lvl_r, 8'b0};

  irq_frame_writer #(.AW(AW), .DW(DW), .NW(NW)) u_writer (
    .clk(clk), .rst(rst), .start(fw_start), .sp_in(sp_r), .words(fw_words),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .fin(fw_fin), .sp_out(fw_sp)
  );

  irq_vector_reader #(.AW(AW), .DW(DW)) u_reader (
    .clk(clk), .rst(rst), .start(vr_start), .base(vaddr_r),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
    .fin(vr_fin), .value(vr_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      halted   <= 1'b0;
      restart  <= 1'b0;
      done     <= 1'b0;
      fw_start <= 1'b0;
      vr_start <= 1'b0;
      lvl_r    <= '0;
      ext_r    <= 1'b0;
      pc_r     <= '0;
      sr_old   <= '0;
      sr_r     <= '0;
      vaddr_r  <= '0;
      isp_r    <= '0;
      sp_r     <= '0;
      usp_r    <= '0;
      msp_r    <= '0;
      fw_words <= '0;
      pc_out   <= '0;
      sr_out   <= '0;
      a7_out   <= '0;
      usp_out  <= '0;
      msp_out  <= '0;
    end else begin
      restart  <= 1'b0;
      done     <= 1'b0;
      fw_start <= 1'b0;
      vr_start <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            busy     <= 1'b1;
            lvl_r    <= req_level;
            ext_r    <= model_ext;
            pc_r     <= pc_in;
            sr_old   <= sr_in;
            vaddr_r  <= vbr_in + AW'(off_in);
            isp_r    <= isp_in;
            msp_r    <= msp_in;
            if (halted) begin
              halted  <= 1'b0;
              restart <= 1'b1;
            end
            if (!sr_in[SR_S_BIT]) begin
              usp_r <= a7_in;
              sp_r  <= (model_ext && sr_in[SR_M_BIT]) ? msp_in : isp_in;
            end else begin
              usp_r <= usp_in;
              sp_r  <= a7_in;
            end
            fw_words <= {sr_in, pc_in[31:16], pc_in[15:0], {FMT_NORMAL, off_in}};
            fw_start <= 1'b1;
            state    <= ST_FRAME;
          end else if (halt_set) begin
            halted <= 1'b1;
          end
        end
        ST_FRAME: begin
          if (fw_fin) begin
            sr_r <= sr_new;
            if (ext_r && sr_new[SR_M_BIT]) begin
              msp_r    <= fw_sp;
              sp_r     <= isp_r;
              fw_words <= {sr_new, pc_r[31:16], pc_r[15:0], {FMT_THROW, off_r}};
              fw_start <= 1'b1;
              state    <= ST_FRAME2;
            end else begin
              sp_r     <= fw_sp;
              vr_start <= 1'b1;
              state    <= ST_VEC;
            end
          end
        end
        ST_FRAME2: begin
          if (fw_fin) begin
            sp_r           <= fw_sp;
            sr_r[SR_M_BIT] <= 1'b0;
            vr_start       <= 1'b1;
            state          <= ST_VEC;
          end
        end
        default: begin
          if (vr_fin) begin
            done    <= 1'b1;
            busy    <= 1'b0;
            halted  <= 1'b0;
            pc_out  <= vr_value;
            sr_out  <= sr_r;
            a7_out  <= sp_r;
            usp_out <= usp_r;
            msp_out <= msp_r;
            state   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R8: completion is a single-cycle pulse and leaves the block idle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4: completed status word is supervisor with both trace bits clear
  a_r4_sr_super: assert property (@(posedge clk) disable iff (rst)
    done |-> (sr_out[13] && !sr_out[15] && !sr_out[14]));
  // R10: wake pulse only while busy and awake
  a_r10_restart: assert property (@(posedge clk) disable iff (rst)
    restart |-> (busy && !halted));
  // R9: no memory traffic while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !fw_start) |-> (!wr_valid && !rd_valid));
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_level = '0;
  logic        halt_set = 1'b0;
  logic        model_ext = 1'b0;
  logic [15:0] sr_in = '0;
  logic [31:0] pc_in = '0, vbr_in = '0, a7_in = '0, usp_in = '0, isp_in = '0, msp_in = '0;
  logic        wr_valid, rd_valid, busy, halted, restart, done;
  logic [31:0] wr_addr, rd_addr, pc_out, a7_out, usp_out, msp_out;
  logic [15:0] wr_data, rd_data, sr_out;
  logic        wr_ready, rd_ready;
  logic [7:0]  lf;

  int n_chk = 0;
  int n_fail = 0;
  int restart_seen = 0;

  typedef struct { logic [31:0] a; logic [15:0] d; string tag; } wr_item_t;
  wr_item_t exp_q[$];

  always #10 clk = ~clk;

  irq_entry_seq u_irq_entry_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .halt_set(halt_set), .model_ext(model_ext), .sr_in(sr_in), .pc_in(pc_in),
    .vbr_in(vbr_in), .a7_in(a7_in), .usp_in(usp_in), .isp_in(isp_in), .msp_in(msp_in),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
    .busy(busy), .halted(halted), .restart(restart), .done(done),
    .pc_out(pc_out), .sr_out(sr_out), .a7_out(a7_out), .usp_out(usp_out), .msp_out(msp_out)
  );

  function automatic logic [15:0] mem_word(input logic [31:0] a);
    return a[16:1] ^ 16'h5A3C;
  endfunction
  assign rd_data = mem_word(rd_addr);

  always @(posedge clk) begin
    if (rst) lf <= 8'h01;
    else     lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    wr_ready <= lf[0] | lf[2];
    rd_ready <= lf[1] | lf[3];
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes as handshakes happen
  always @(negedge clk) begin
    if (!rst && restart) restart_seen++;
    if (!rst && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected write", wr_addr, 32'h0);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(wr_addr == it.a, {it.tag, " addr"}, wr_addr, it.a);
        check(wr_data == it.d, {it.tag, " data"}, {16'h0, wr_data}, {16'h0, it.d});
      end
    end
  end

  task automatic push_frame(inout logic [31:0] sp, input logic [3:0] fmt, input logic [11:0] off,
                            input logic [31:0] pc, input logic [15:0] sr, input string tag);
    wr_item_t it;
    it.tag = tag;
    it.a = sp - 2; it.d = {fmt, off};    exp_q.push_back(it);
    it.a = sp - 4; it.d = pc[15:0];      exp_q.push_back(it);
    it.a = sp - 6; it.d = pc[31:16];     exp_q.push_back(it);
    it.a = sp - 8; it.d = sr;            exp_q.push_back(it);
    sp = sp - 8;
  endtask

  task automatic run(input logic [2:0] lvl, input logic [15:0] sr, input logic ext,
                     input logic [31:0] a7, input logic [31:0] usp, input logic [31:0] isp,
                     input logic [31:0] msp, input logic extra_req);
    logic [31:0] sp, eusp, emsp, epc, vbr, pc;
    logic [11:0] off;
    logic [15:0] nsr;
    int waited;
    pc  = 32'h1234_0000 | {29'h0, lvl} << 4 | 32'h0000_8000;
    vbr = 32'h0000_4000;
    off = 12'h060 + {7'h0, lvl, 2'b00};
    if (sr[13]) begin sp = a7; eusp = usp; end
    else begin sp = (ext && sr[12]) ? msp : isp; eusp = a7; end
    push_frame(sp, 4'h0, off, pc, sr, "R3 frame");
    nsr = (sr & 16'h38FF) | 16'h2000 | {5'h0, lvl, 8'h0};
    emsp = msp;
    if (ext && nsr[12]) begin
      emsp = sp;
      sp = isp;
      push_frame(sp, 4'h1, off, pc, nsr, "R5 second frame");
      nsr[12] = 1'b0;
    end
    epc = {mem_word(vbr + {20'h0, off}), mem_word(vbr + {20'h0, off} + 2)};
    @(negedge clk);
    req_level = lvl; sr_in = sr; model_ext = ext; a7_in = a7; usp_in = usp;
    isp_in = isp; msp_in = msp; pc_in = pc; vbr_in = vbr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", {31'h0, busy}, 32'h1);
    if (extra_req) begin
      repeat (3) @(negedge clk);
      req_level = 3'd6; sr_in = 16'h0000; pc_in = 32'hDEAD_BEE0; a7_in = 32'h9999_0000;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    waited = 0;
    while (!done && waited < 2000) begin @(negedge clk); waited++; end
    check(done == 1'b1, "R8 done reached", {31'h0, done}, 32'h1);
    check(pc_out == epc, "R1 handler address", pc_out, epc);
    check(sr_out == nsr, "R4 R5 R6 status word", {16'h0, sr_out}, {16'h0, nsr});
    check(a7_out == sp, "R2 R3 R5 final stack", a7_out, sp);
    check(usp_out == eusp, "R2 user stack", usp_out, eusp);
    check(msp_out == emsp, "R5 R6 master stack", msp_out, emsp);
    check(exp_q.size() == 0, "R3 all frame words written", exp_q.size(), 32'h0);
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", {31'h0, done}, 32'h0);
    repeat (12) @(negedge clk);
    check(busy == 1'b0, "R9 stays idle", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !halted && !wr_valid, "R8 reset state",
          {28'h0, busy, done, halted, wr_valid}, 32'h0);
    // R6: base model, user mode, master bit set but ignored
    run(3'd3, 16'h1704, 1'b0, 32'h0010_0000, 32'h0, 32'h0020_0000, 32'h0030_0000, 1'b0);
    // R2: base model, supervisor mode, top level
    run(3'd7, 16'hA300, 1'b0, 32'h0040_0010, 32'h0011_1110, 32'h0020_0000, 32'h0030_0000, 1'b0);
    // R5: extended, user mode with master bit
    run(3'd5, 16'h1000, 1'b1, 32'h0010_0100, 32'h0, 32'h0020_0200, 32'h0030_0300, 1'b0);
    // R5: extended, supervisor on master stack, level 1
    run(3'd1, 16'h3600, 1'b1, 32'h0030_0400, 32'h0022_2220, 32'h0020_0600, 32'h0030_0400, 1'b0);
    // R2: extended, user mode, master clear, level 0 boundary
    run(3'd0, 16'h4015, 1'b1, 32'h0010_0800, 32'h0, 32'h0020_0800, 32'h0030_0800, 1'b0);
    // R9: second request while busy is dropped
    run(3'd2, 16'h2000, 1'b0, 32'h0050_0000, 32'h0033_3330, 32'h0020_0a00, 32'h0030_0a00, 1'b1);
    // R10: stop, then wake through a request
    @(negedge clk); halt_set = 1'b1;
    @(negedge clk); halt_set = 1'b0;
    check(halted == 1'b1, "R10 halted set", {31'h0, halted}, 32'h1);
    restart_seen = 0;
    run(3'd4, 16'h0000, 1'b0, 32'h0060_0000, 32'h0, 32'h0020_0c00, 32'h0030_0c00, 1'b0);
    check(restart_seen == 1, "R10 one restart pulse", restart_seen, 32'h1);
    check(halted == 1'b0, "R10 halted cleared", {31'h0, halted}, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule